// File: doc/BRIEF.md
# Grid-Addressed Byte Store with Address Latch

This block stores 256 bytes in a square array of 16 rows by 16 columns of byte registers. A master on a shared 8-bit bus first places an address on the bus and pulses an address-load strobe. This loads an internal 8-bit address latch. The latched address is split into two nibbles. Each nibble is decoded into a one-hot set of 16 select lines, one set for rows and one for columns. The single cell where an active row line meets an active column line is the only one that reacts to the bus strobes.

With the address latched, a set strobe writes the bus value into the selected cell at the next rising edge. An enable strobe puts the selected cell's value on the bus output in the same cycle. The bus is split into an input byte, an output byte and a drive flag, so no tristate net is needed. Every cell is reached in the same number of cycles, whatever the address and whatever was accessed before.

Top module: `gridram_top`

## Requirements
- R1: The block holds 256 independent 8-bit cells; a distinct value written to each address is read back unchanged from that address.
- R2: The address latch loads the 8-bit `busIn` value on a rising edge where `addrLoad` is high, and keeps its value on every other edge.
- R3: Bits 7:4 of the latched address choose the row and bits 3:0 choose the column, so addresses 0x12 and 0x21 name different cells.
- R4: Exactly one row line and exactly one column line are active in every cycle, and the active row line is the one indexed by the upper nibble.
- R5: On a rising edge with `setStrobe` high, only the selected cell captures `busIn`; all other cells keep their contents.
- R6: While `enableStrobe` is high, `busOut` equals the selected cell's value in the same cycle and `busDriven` is 1.
- R7: While `enableStrobe` is low, `busOut` is 0x00 and `busDriven` is 0.
- R8: A read of any address is valid in the cycle right after the edge that loads that address, with no dependence on the previous address or on the order of accesses.
- R9: A synchronous reset (`rst` high at a rising edge) clears the address latch and all 256 cells to zero.
- R10: When `setStrobe` and `enableStrobe` are high in the same cycle, `busOut` shows the cell's old value during that cycle and the new value is stored at the edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| addrLoad | input | 1 | Load `busIn` into the address latch |
| setStrobe | input | 1 | Write `busIn` into the selected cell |
| enableStrobe | input | 1 | Drive the selected cell's value onto `busOut` |
| busIn | input | 8 | Bus value seen by the block (address or write data) |
| busOut | output | 8 | Value the block drives on the bus; zero when not driving |
| busDriven | output | 1 | High when the block is driving the bus |

## Verification
A full sweep writes a distinct value to each of the 256 addresses and then reads every one back. This shows that no two addresses alias onto the same cell. Swapped-nibble addresses such as 0x12 and 0x21, together with the neighbours of a single written cell, show whether the row and column decode is the right way round and whether a write stays confined to one cell. Reads in a scattered order, a changing bus while the address is held, a combined set-and-enable cycle and a reset after writes separate the cases of latch hold, order independence, read-during-write and clearing.

// File: rtl/gridram_pkg.sv
package gridram_pkg;
  // Strobes the control half hands to the storage array each cycle
  typedef struct packed {
    logic cellWrite;
    logic busDrive;
  } gridCtrl_t;
endpackage

// File: rtl/gridram_ctrl.sv
module gridram_ctrl
  import gridram_pkg::*;
#(
  parameter int ROW_BITS = 4,
  parameter int COL_BITS = 4,
  localparam int ADDR_W  = ROW_BITS + COL_BITS,
  localparam int NUM_ROWS = 1 << ROW_BITS,
  localparam int NUM_COLS = 1 << COL_BITS
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                addrLoad,
  input  logic                setStrobe,
  input  logic                enableStrobe,
  input  logic [ADDR_W-1:0]   busAddr,
  output logic [ADDR_W-1:0]   addrQ,
  output logic [NUM_ROWS-1:0] rowSel,
  output logic [NUM_COLS-1:0] colSel,
  output gridCtrl_t           strobes
);
  logic [ROW_BITS-1:0] rowIdx;
  logic [COL_BITS-1:0] colIdx;

  always_ff @(posedge clk) begin
    if (rst)           addrQ <= '0;
    else if (addrLoad) addrQ <= busAddr;
  end

  assign rowIdx = addrQ[ADDR_W-1:COL_BITS];
  assign colIdx = addrQ[COL_BITS-1:0];

  // One-hot row and column decoders
  for (genvar r = 0; r < NUM_ROWS; r++) begin : g_rowDec
    assign rowSel[r] = (rowIdx == ROW_BITS'(r));
  end
  for (genvar c = 0; c < NUM_COLS; c++) begin : g_colDec
    assign colSel[c] = (colIdx == COL_BITS'(c));
  end

  always_comb begin
    strobes.cellWrite = setStrobe;
    strobes.busDrive  = enableStrobe;
  end
endmodule

// File: rtl/gridram_datapath.sv
module gridram_datapath
  import gridram_pkg::*;
#(
  parameter int ROW_BITS = 4,
  parameter int COL_BITS = 4,
  parameter int DATA_W   = 8,
  localparam int NUM_ROWS = 1 << ROW_BITS,
  localparam int NUM_COLS = 1 << COL_BITS,
  localparam int NUM_CELLS = NUM_ROWS * NUM_COLS
) (
  input  logic                clk,
  input  logic                rst,
  input  gridCtrl_t           strobes,
  input  logic [NUM_ROWS-1:0] rowSel,
  input  logic [NUM_COLS-1:0] colSel,
  input  logic [DATA_W-1:0]   busIn,
  output logic [DATA_W-1:0]   busOut,
  output logic                busDriven
);
  logic [DATA_W-1:0] cellVal [NUM_CELLS];
  logic [DATA_W-1:0] readOr;

  for (genvar r = 0; r < NUM_ROWS; r++) begin : g_row
    for (genvar c = 0; c < NUM_COLS; c++) begin : g_col
      logic              cellHit;
      logic [DATA_W-1:0] cellQ;
      // A cell answers only where its row and column lines cross
      assign cellHit = rowSel[r] & colSel[c];
      always_ff @(posedge clk) begin
        if (rst)                               cellQ <= '0;
        else if (strobes.cellWrite && cellHit) cellQ <= busIn;
      end
      assign cellVal[r*NUM_COLS + c] = cellHit ? cellQ : '0;
    end
  end

  // Unselected cells contribute zero, so an OR gathers the one selected value
  always_comb begin
    readOr = '0;
    for (int i = 0; i < NUM_CELLS; i++) readOr |= cellVal[i];
  end

  assign busOut    = strobes.busDrive ? readOr : '0;
  assign busDriven = strobes.busDrive;
endmodule

// File: rtl/gridram_top.sv
module gridram_top
  import gridram_pkg::*;
#(
  parameter int ROW_BITS = 4,
  parameter int COL_BITS = 4,
  localparam int ADDR_W   = ROW_BITS + COL_BITS,
  localparam int DATA_W   = ADDR_W,
  localparam int NUM_ROWS = 1 << ROW_BITS,
  localparam int NUM_COLS = 1 << COL_BITS
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              addrLoad,
  input  logic              setStrobe,
  input  logic              enableStrobe,
  input  logic [DATA_W-1:0] busIn,
  output logic [DATA_W-1:0] busOut,
  output logic              busDriven
);
  gridCtrl_t           strobes;
  logic [ADDR_W-1:0]   addrQ;
  logic [NUM_ROWS-1:0] rowSel;
  logic [NUM_COLS-1:0] colSel;

  gridram_ctrl #(.ROW_BITS(ROW_BITS), .COL_BITS(COL_BITS)) u_ctrl (
    .clk(clk), .rst(rst), .addrLoad(addrLoad), .setStrobe(setStrobe),
    .enableStrobe(enableStrobe), .busAddr(busIn), .addrQ(addrQ),
    .rowSel(rowSel), .colSel(colSel), .strobes(strobes)
  );

  gridram_datapath #(.ROW_BITS(ROW_BITS), .COL_BITS(COL_BITS), .DATA_W(DATA_W)) u_data (
    .clk(clk), .rst(rst), .strobes(strobes), .rowSel(rowSel), .colSel(colSel),
    .busIn(busIn), .busOut(busOut), .busDriven(busDriven)
  );
endmodule

// File: rtl/gridram_checks.sv
module gridram_checks #(
  parameter int ROW_BITS = 4,
  parameter int COL_BITS = 4,
  localparam int ADDR_W   = ROW_BITS + COL_BITS,
  localparam int NUM_ROWS = 1 << ROW_BITS,
  localparam int NUM_COLS = 1 << COL_BITS
) (
  input logic                clk,
  input logic                rst,
  input logic                addrLoad,
  input logic                setStrobe,
  input logic                enableStrobe,
  input logic [ADDR_W-1:0]   busIn,
  input logic [ADDR_W-1:0]   busOut,
  input logic                busDriven,
  input logic [ADDR_W-1:0]   addrQ,
  input logic [NUM_ROWS-1:0] rowSel,
  input logic [NUM_COLS-1:0] colSel
);
  // R2: latch loads on strobe
  p_addr_load_r2: assert property (@(posedge clk) disable iff (rst)
    addrLoad |=> addrQ == $past(busIn));
  // R2: latch holds otherwise
  p_addr_hold_r2: assert property (@(posedge clk) disable iff (rst)
    !addrLoad |=> $stable(addrQ));
  // R4: one row and one column line
  p_row_onehot_r4: assert property (@(posedge clk) disable iff (rst)
    $countones(rowSel) == 1);
  p_col_onehot_r4: assert property (@(posedge clk) disable iff (rst)
    $countones(colSel) == 1);
  // R3: upper nibble picks the row line
  p_row_index_r3: assert property (@(posedge clk) disable iff (rst)
    rowSel[addrQ[ADDR_W-1:COL_BITS]] && colSel[addrQ[COL_BITS-1:0]]);
  // R7: silent bus when not enabled
  p_idle_bus_r7: assert property (@(posedge clk) disable iff (rst)
    !enableStrobe |-> (busOut == '0) && !busDriven);
  // R6: driving flag follows enable
  p_drive_flag_r6: assert property (@(posedge clk) disable iff (rst)
    enableStrobe |-> busDriven);
  // R5: a written value is read back at the same address next cycle
  p_write_read_r5: assert property (@(posedge clk) disable iff (rst)
    (setStrobe && !addrLoad) ##1 enableStrobe |-> busOut == $past(busIn));
endmodule

bind gridram_top gridram_checks #(.ROW_BITS(ROW_BITS), .COL_BITS(COL_BITS)) u_checks (
  .clk(clk), .rst(rst), .addrLoad(addrLoad), .setStrobe(setStrobe),
  .enableStrobe(enableStrobe), .busIn(busIn), .busOut(busOut),
  .busDriven(busDriven), .addrQ(addrQ), .rowSel(rowSel), .colSel(colSel)
);

// File: tb/gridram_top_tb.sv
module gridram_top_tb;
  logic       clk = 0;
  logic       rst = 1;
  logic       addrLoad = 0;
  logic       setStrobe = 0;
  logic       enableStrobe = 0;
  logic [7:0] busIn = '0;
  logic [7:0] busOut;
  logic       busDriven;

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 0;

  gridram_top u_dut (
    .clk(clk), .rst(rst), .addrLoad(addrLoad), .setStrobe(setStrobe),
    .enableStrobe(enableStrobe), .busIn(busIn), .busOut(busOut), .busDriven(busDriven)
  );

  always #2 clk = ~clk;

  function automatic logic [7:0] pat(input int a);
    return 8'(a * 37 + 11);
  endfunction

  task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
    nChecks++;
    if (got !== exp) begin
      nFails++;
      $display("FAIL %s: got 0x%02h expected 0x%02h", req, got, exp);
    end
  endtask

  task automatic loadAddr(input logic [7:0] a);
    @(negedge clk); addrLoad = 1; busIn = a;
    @(negedge clk); addrLoad = 0; busIn = 8'hEE;
  endtask

  task automatic writeByte(input logic [7:0] d);
    @(negedge clk); setStrobe = 1; busIn = d;
    @(negedge clk); setStrobe = 0; busIn = 8'hEE;
  endtask

  // Reads in the phase right after the previous negedge
  task automatic readNow(output logic [7:0] v, output logic drv);
    enableStrobe = 1; #1;
    v = busOut; drv = busDriven;
    enableStrobe = 0;
  endtask

  task automatic readAt(input logic [7:0] a, output logic [7:0] v, output logic drv);
    loadAddr(a);
    readNow(v, drv);
  endtask

  task automatic testResetState;
    logic [7:0] v; logic d;
    #1;
    check("R7 idle bus after reset", busOut, 8'h00);
    check("R7 idle flag after reset", {7'b0, busDriven}, 8'h00);
    readNow(v, d);
    check("R9 latch cleared reads cell 0 as zero", v, 8'h00);
    readAt(8'hFF, v, d);
    check("R9 cell 0xFF zero", v, 8'h00);
    check("R6 drive flag during read", {7'b0, d}, 8'h01);
  endtask

  task automatic testFullSweep;
    logic [7:0] v; logic d;
    for (int a = 0; a < 256; a++) begin
      loadAddr(8'(a)); writeByte(pat(a));
    end
    for (int a = 0; a < 256; a++) begin
      readAt(8'(a), v, d);
      check("R1 sweep readback", v, pat(a));
    end
  endtask

  task automatic testNibbleSwap;
    logic [7:0] v; logic d;
    loadAddr(8'h12); writeByte(8'hC1);
    loadAddr(8'h21); writeByte(8'h3D);
    readAt(8'h12, v, d); check("R3 cell 0x12", v, 8'hC1);
    readAt(8'h21, v, d); check("R3 cell 0x21", v, 8'h3D);
  endtask

  task automatic testNeighbours;
    logic [7:0] v; logic d;
    loadAddr(8'h55); writeByte(8'h99);
    readAt(8'h55, v, d); check("R5 target written", v, 8'h99);
    readAt(8'h54, v, d); check("R5 left neighbour kept", v, pat(8'h54));
    readAt(8'h56, v, d); check("R5 right neighbour kept", v, pat(8'h56));
    readAt(8'h45, v, d); check("R5 upper neighbour kept", v, pat(8'h45));
    readAt(8'h65, v, d); check("R5 lower neighbour kept", v, pat(8'h65));
  endtask

  task automatic testHoldAndIdle;
    logic [7:0] v; logic d;
    loadAddr(8'h2A); writeByte(8'h41);
    // bus wanders with addrLoad low; latch must stay on 0x2A
    for (int i = 0; i < 4; i++) begin
      @(negedge clk); busIn = 8'(i * 50 + 7);
    end
    @(negedge clk);
    readNow(v, d); check("R2 latch held through bus changes", v, 8'h41);
    #1;
    check("R7 bus zero when enable low", busOut, 8'h00);
    check("R7 flag low when enable low", {7'b0, busDriven}, 8'h00);
  endtask

  task automatic testScatteredOrder;
    logic [7:0] v; logic d;
    readAt(8'hC8, v, d); check("R8 far address 200", v, pat(200));
    readAt(8'h2A, v, d); check("R8 back to 42", v, 8'h41);
    readAt(8'h49, v, d); check("R8 address 73", v, pat(73));
    readAt(8'h00, v, d); check("R8 address 0", v, pat(0));
    readAt(8'hFF, v, d); check("R8 address 255", v, pat(255));
  endtask

  task automatic testReadDuringWrite;
    logic [7:0] v; logic d;
    loadAddr(8'h80);
    @(negedge clk);
    setStrobe = 1; enableStrobe = 1; busIn = 8'h7E; #1;
    check("R10 old value during combined cycle", busOut, pat(8'h80));
    @(negedge clk);
    setStrobe = 0; enableStrobe = 0; busIn = 8'hEE;
    readNow(v, d); check("R10 new value stored", v, 8'h7E);
  endtask

  task automatic testResetClears;
    logic [7:0] v; logic d;
    @(negedge clk); rst = 1;
    @(negedge clk); rst = 0;
    readNow(v, d); check("R9 latch and cell 0 cleared", v, 8'h00);
    readAt(8'h55, v, d); check("R9 cell 0x55 cleared", v, 8'h00);
    readAt(8'hC8, v, d); check("R9 cell 200 cleared", v, 8'h00);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    testResetState();
    testFullSweep();
    testNibbleSwap();
    testNeighbours();
    testHoldAndIdle();
    testScatteredOrder();
    testReadDuringWrite();
    testResetClears();
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    #(4 * 50000);
    if (!finished) begin
      nChecks++; nFails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end
endmodule